// File: doc/BRIEF.md
# Host-Side Low-Pin-Count Bus Controller Register Bank

This block holds the configuration and interrupt registers of a host-side low-pin-count bus controller. It also holds a small interrupt register set for the internal bus master that reaches that controller. Both sets sit on a 32-bit internal register bus. The controller window is 4 KB long and based at 0xC0012000. The master window is 8 KB long and based at 0xC0010000. Both bases and spans are parameters.

The serial-interrupt engine and the bus-cycle engine live outside the block. They report events through one-cycle strobes that set sticky status bits. Software clears a status bit by writing a 1 to it. The block decodes the stored configuration into ready-to-use values for those engines. It drives two interrupt outputs: one for the controller and one for the master. The controller interrupt also reaches the master's raw input lines.

A read is accepted in one cycle, and its data appears with `bus_rvalid` on the next cycle. A write takes effect at the clock edge where it is presented. Only aligned full-word accesses are valid.

Top module: `lhc_regbank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except the read-size register, which reads 0x02000000. `ctl_irq`, `mst_irq` and `sirq_en` are low, `fw_rd_bytes` is 4 and `sirq_start_clks` is 4.
- R2: A read presented with `bus_sel`=1 and `bus_we`=0 returns its data on `bus_rdata` with `bus_rvalid`=1 in the next cycle. The controller-window offsets are: segment/ID select 0x24 (all 32 bits writable), read size 0x28 (bits 26:24 writable), serial-interrupt control 0x30 (bits 31, 30, 25:24 writable), interrupt mask 0x34, interrupt status 0x38 and error address 0x40. Bits that are not writable read 0.
- R3: A read of any address outside both windows, or of an offset inside a window that holds no register, returns 0xFFFFFFFF. A write to such an address changes no register.
- R4: An access with `bus_be` other than 4'b1111, or with `bus_addr[1:0]` not zero, is invalid. Its read returns 0xFFFFFFFF and its write changes nothing.
- R5: A 1 on bit n of `ctl_evt` sets controller status bit n, for the implemented bits only. Those are mask 0xFFFF84FF: bits 31:15 are serial lines 0..16, bit 10 is bus reset, bits 7:2 are sync errors and bits 1:0 are bus-master requests. Strobes on other bits are ignored.
- R6: Writing the controller status (0x38) or the master status (0x50) clears each bit written as 1 and leaves the others. When a set and a clear hit the same bit in the same cycle, the bit stays 1.
- R7: `err_load`=1 loads `err_val` into the error address register. Bus writes to 0x40 are ignored.
- R8: `ctl_irq` is 1 exactly when some bit of (controller status AND controller mask) is 1. It follows a register change with no extra cycle.
- R9: The master raw input (0x5C) is read-only. It reads (`mst_lines` with `ctl_irq` ORed into bit 11) XOR polarity (0x58). Writes to 0x5C are ignored.
- R10: Each cycle in which a raw input bit is 1 sets master status bit n, so the bit cannot be cleared while its raw input stays high. `mst_irq` is 1 exactly when some bit of (master status AND master mask at 0x54) is 1.
- R11: `sirq_en` is serial control bit 31 and `sirq_quiet` is bit 30. `sirq_start_clks` decodes bits 25:24 as 0 to 4, 1 to 6, and 2 or 3 to 8.
- R12: `fw_rd_bytes` decodes read-size bits 26:24 as 0 to 1, 1 to 2, 2 to 4, 4 to 16 and 7 to 128, and any other code to 4. `fw_seg_sel` shows the segment/ID select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Full byte address |
| bus_be | input | 4 | Byte enables; only 4'b1111 is valid |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| ctl_evt | input | 32 | One-cycle set strobes for controller status |
| err_load | input | 1 | Load strobe for the error address |
| err_val | input | 32 | Error address to load |
| mst_lines | input | 32 | External master interrupt lines |
| fw_seg_sel | output | 32 | Segment/ID select value |
| fw_rd_bytes | output | 8 | Decoded firmware read size in bytes |
| sirq_en | output | 1 | Serial interrupt enable |
| sirq_quiet | output | 1 | Serial interrupt quiet mode |
| sirq_start_clks | output | 4 | Start-frame width in clocks |
| ctl_irq | output | 1 | Controller interrupt |
| mst_irq | output | 1 | Master interrupt |

## Verification
A wrong status, mask or polarity bit shows on the interrupt outputs in the same cycle it is stored. A master status bit shows one cycle later, because it is set from the raw input on the next edge. The bench therefore checks the interrupt outputs right after each strobe or write, in addition to reading the registers back. Decode faults show only on the read data of the next cycle, so the bench reads unimplemented offsets, addresses outside the windows, sub-word accesses and neighbouring registers after each stray write.

// File: rtl/lhc_pkg.sv
// Shared constants and types for the host-controller register bank.
// Assumes a 32-bit register bus with byte addresses.
package lhc_pkg;
    localparam int DW   = 32;
    localparam int BE_W = DW / 8;

    // Implemented / writable bit masks
    localparam logic [DW-1:0] CSTAT_IMPL = 32'hFFFF_84FF;
    localparam logic [DW-1:0] RDSZ_IMPL  = 32'h0700_0000;
    localparam logic [DW-1:0] SCTL_IMPL  = 32'hC300_0000;
    localparam logic [DW-1:0] RDSZ_RST   = 32'h0200_0000;

    // Offsets inside the controller window
    localparam logic [DW-1:0] OFF_SEG    = 32'h24;
    localparam logic [DW-1:0] OFF_RDSZ   = 32'h28;
    localparam logic [DW-1:0] OFF_SCTL   = 32'h30;
    localparam logic [DW-1:0] OFF_CMASK  = 32'h34;
    localparam logic [DW-1:0] OFF_CSTAT  = 32'h38;
    localparam logic [DW-1:0] OFF_ERR    = 32'h40;
    // Offsets inside the master window
    localparam logic [DW-1:0] OFF_MSTAT  = 32'h50;
    localparam logic [DW-1:0] OFF_MMASK  = 32'h54;
    localparam logic [DW-1:0] OFF_MPOL   = 32'h58;
    localparam logic [DW-1:0] OFF_MRAW   = 32'h5C;

    // Master raw line fed by the controller interrupt
    localparam int CIRQ_BIT = 11;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SEG, SEL_RDSZ, SEL_SCTL, SEL_CMASK, SEL_CSTAT,
        SEL_ERR, SEL_MSTAT, SEL_MMASK, SEL_MPOL, SEL_MRAW
    } reg_sel_e;
endpackage

// File: rtl/lhc_addr_dec.sv
// Address decoder: maps a full byte address to one register select.
// Assumes each span is a power of two and each base is aligned to its span.
// Invalid widths and misaligned addresses decode to SEL_NONE.
module lhc_addr_dec
    import lhc_pkg::*;
#(
    parameter logic [DW-1:0] MST_BASE = 32'hC001_0000,
    parameter logic [DW-1:0] MST_SPAN = 32'h0000_2000,
    parameter logic [DW-1:0] CTL_BASE = 32'hC001_2000,
    parameter logic [DW-1:0] CTL_SPAN = 32'h0000_1000
) (
    input  logic [DW-1:0]   addr,
    input  logic [BE_W-1:0] be,
    output reg_sel_e        sel
);
    localparam logic [DW-1:0] MST_OMASK = MST_SPAN - 32'd1;
    localparam logic [DW-1:0] CTL_OMASK = CTL_SPAN - 32'd1;

    logic          word_ok;
    logic [DW-1:0] moff;
    logic [DW-1:0] coff;

    // Pick the register addressed by a valid full-word access
    always_comb begin
        word_ok = (be == {BE_W{1'b1}}) && (addr[1:0] == 2'b00);
        moff    = addr & MST_OMASK;
        coff    = addr & CTL_OMASK;
        sel     = SEL_NONE;
        if (word_ok && ((addr & ~MST_OMASK) == MST_BASE)) begin
            case (moff)
                OFF_MSTAT: sel = SEL_MSTAT;
                OFF_MMASK: sel = SEL_MMASK;
                OFF_MPOL:  sel = SEL_MPOL;
                OFF_MRAW:  sel = SEL_MRAW;
                default:   sel = SEL_NONE;
            endcase
        end else if (word_ok && ((addr & ~CTL_OMASK) == CTL_BASE)) begin
            case (coff)
                OFF_SEG:   sel = SEL_SEG;
                OFF_RDSZ:  sel = SEL_RDSZ;
                OFF_SCTL:  sel = SEL_SCTL;
                OFF_CMASK: sel = SEL_CMASK;
                OFF_CSTAT: sel = SEL_CSTAT;
                OFF_ERR:   sel = SEL_ERR;
                default:   sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lhc_w1c_status.sv
// Sticky status register with write-one-to-clear.
// Assumes set_i is sampled every cycle; a set beats a clear on the same bit.
// Bits outside IMPL always hold 0.
module lhc_w1c_status #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] status_o
);
    logic [W-1:0] clr_mask;

    // Clear pattern that applies this cycle
    assign clr_mask = clr_we ? clr_data : '0;

    // Update: clear the written ones, then apply the set strobes
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= ((status_o & ~clr_mask) | set_i) & IMPL;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL) != '0) |=> ((status_o & $past(set_i & IMPL)) == $past(set_i & IMPL)))
        else $error("set strobe lost"); // R6
    AST_CLEAR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_o) & ~status_o & ~$past(clr_mask)) == '0))
        else $error("status bit dropped without a write of one"); // R6
endmodule

// File: rtl/lhc_ctl_regs.sv
// Controller register set: configuration, interrupt mask/status and error address.
// Assumes write data is applied only when the decoder selected a register.
// Also decodes the stored fields for the external engines.
module lhc_ctl_regs
    import lhc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    input  logic          err_load,
    input  logic [DW-1:0] err_val,
    output logic [DW-1:0] seg_q,
    output logic [DW-1:0] rdsz_q,
    output logic [DW-1:0] sctl_q,
    output logic [DW-1:0] cmask_q,
    output logic [DW-1:0] cstat_q,
    output logic [DW-1:0] err_q,
    output logic          ctl_irq,
    output logic [7:0]    rd_bytes,
    output logic [3:0]    start_clks
);
    // Configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q   <= '0;
            rdsz_q  <= RDSZ_RST;
            sctl_q  <= '0;
            cmask_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_SEG:   seg_q   <= wdata;
                SEL_RDSZ:  rdsz_q  <= wdata & RDSZ_IMPL;
                SEL_SCTL:  sctl_q  <= wdata & SCTL_IMPL;
                SEL_CMASK: cmask_q <= wdata & CSTAT_IMPL;
                default: ;
            endcase
        end
    end

    // Error address: loaded only by the bus-cycle engine
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= '0;
        else if (err_load) err_q <= err_val;
    end

    lhc_w1c_status #(.W(DW), .IMPL(CSTAT_IMPL)) u_cstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt),
        .clr_we   (wr_en && (sel == SEL_CSTAT)),
        .clr_data (wdata),
        .status_o (cstat_q)
    );

    // Masked controller interrupt
    assign ctl_irq = |(cstat_q & cmask_q);

    // Field decode for the external engines
    always_comb begin
        case (rdsz_q[26:24])
            3'd0:    rd_bytes = 8'd1;
            3'd1:    rd_bytes = 8'd2;
            3'd2:    rd_bytes = 8'd4;
            3'd4:    rd_bytes = 8'd16;
            3'd7:    rd_bytes = 8'd128;
            default: rd_bytes = 8'd4;
        endcase
        case (sctl_q[25:24])
            2'd0:    start_clks = 4'd4;
            2'd1:    start_clks = 4'd6;
            default: start_clks = 4'd8;
        endcase
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_load |=> $stable(err_q))
        else $error("error address moved without a load"); // R7
endmodule

// File: rtl/lhc_mst_regs.sv
// Master interrupt register set: level-set status, mask, polarity, raw view.
// Assumes the controller interrupt shares raw line CIRQ_BIT with mst_lines.
module lhc_mst_regs
    import lhc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic          ctl_irq,
    input  logic [DW-1:0] lines,
    output logic [DW-1:0] mstat_q,
    output logic [DW-1:0] mmask_q,
    output logic [DW-1:0] mpol_q,
    output logic [DW-1:0] mraw,
    output logic          mst_irq
);
    logic [DW-1:0] merged;

    // Raw inputs after merging the controller interrupt and applying polarity
    assign merged = lines | (DW'(ctl_irq) << CIRQ_BIT);
    assign mraw   = merged ^ mpol_q;

    // Mask and polarity written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mmask_q <= '0;
            mpol_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MMASK: mmask_q <= wdata;
                SEL_MPOL:  mpol_q  <= wdata;
                default: ;
            endcase
        end
    end

    lhc_w1c_status #(.W(DW), .IMPL({DW{1'b1}})) u_mstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (mraw),
        .clr_we   (wr_en && (sel == SEL_MSTAT)),
        .clr_data (wdata),
        .status_o (mstat_q)
    );

    // Masked master interrupt
    assign mst_irq = |(mstat_q & mmask_q);

    AST_CIRQ_FEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq && !mpol_q[CIRQ_BIT]) |=> mstat_q[CIRQ_BIT])
        else $error("controller interrupt did not reach master status"); // R9
endmodule

// File: rtl/lhc_regbank.sv
// Top of the host-controller register bank.
// Decodes bus accesses, holds both register sets and returns registered read data.
// Assumes one access per cycle; read data follows one cycle after the request.
module lhc_regbank
    import lhc_pkg::*;
#(
    parameter logic [DW-1:0] MST_BASE = 32'hC001_0000,
    parameter logic [DW-1:0] MST_SPAN = 32'h0000_2000,
    parameter logic [DW-1:0] CTL_BASE = 32'hC001_2000,
    parameter logic [DW-1:0] CTL_SPAN = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [DW-1:0]   bus_addr,
    input  logic [BE_W-1:0] bus_be,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    input  logic [DW-1:0]   ctl_evt,
    input  logic            err_load,
    input  logic [DW-1:0]   err_val,
    input  logic [DW-1:0]   mst_lines,
    output logic [DW-1:0]   fw_seg_sel,
    output logic [7:0]      fw_rd_bytes,
    output logic            sirq_en,
    output logic            sirq_quiet,
    output logic [3:0]      sirq_start_clks,
    output logic            ctl_irq,
    output logic            mst_irq
);
    reg_sel_e      sel;
    logic          wr_en;
    logic          rd_en;
    logic [DW-1:0] seg_q, rdsz_q, sctl_q, cmask_q, cstat_q, err_q;
    logic [DW-1:0] mstat_q, mmask_q, mpol_q, mraw;
    logic [DW-1:0] rd_mux;

    assign wr_en = bus_sel && bus_we;
    assign rd_en = bus_sel && !bus_we;

    lhc_addr_dec #(
        .MST_BASE (MST_BASE), .MST_SPAN (MST_SPAN),
        .CTL_BASE (CTL_BASE), .CTL_SPAN (CTL_SPAN)
    ) u_dec (
        .addr (bus_addr),
        .be   (bus_be),
        .sel  (sel)
    );

    lhc_ctl_regs u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .wdata      (bus_wdata),
        .evt        (ctl_evt),
        .err_load   (err_load),
        .err_val    (err_val),
        .seg_q      (seg_q),
        .rdsz_q     (rdsz_q),
        .sctl_q     (sctl_q),
        .cmask_q    (cmask_q),
        .cstat_q    (cstat_q),
        .err_q      (err_q),
        .ctl_irq    (ctl_irq),
        .rd_bytes   (fw_rd_bytes),
        .start_clks (sirq_start_clks)
    );

    lhc_mst_regs u_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .ctl_irq (ctl_irq),
        .lines   (mst_lines),
        .mstat_q (mstat_q),
        .mmask_q (mmask_q),
        .mpol_q  (mpol_q),
        .mraw    (mraw),
        .mst_irq (mst_irq)
    );

    assign fw_seg_sel = seg_q;
    assign sirq_en    = sctl_q[31];
    assign sirq_quiet = sctl_q[30];

    // Read multiplexer; unmapped selects return all ones
    always_comb begin
        case (sel)
            SEL_SEG:   rd_mux = seg_q;
            SEL_RDSZ:  rd_mux = rdsz_q;
            SEL_SCTL:  rd_mux = sctl_q;
            SEL_CMASK: rd_mux = cmask_q;
            SEL_CSTAT: rd_mux = cstat_q;
            SEL_ERR:   rd_mux = err_q;
            SEL_MSTAT: rd_mux = mstat_q;
            SEL_MMASK: rd_mux = mmask_q;
            SEL_MPOL:  rd_mux = mpol_q;
            SEL_MRAW:  rd_mux = mraw;
            default:   rd_mux = '1;
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid)
        else $error("read not answered"); // R2
    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_NONE)) |=> (bus_rdata == '1))
        else $error("unmapped read not all ones"); // R3
    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_NONE)) |=> ($stable(seg_q) && $stable(rdsz_q) && $stable(sctl_q)
                                          && $stable(cmask_q) && $stable(mmask_q) && $stable(mpol_q)))
        else $error("unmapped write changed a register"); // R4
endmodule

// File: tb/lhc_regbank_bench.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares responses.
module lhc_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] ctl_evt = '0, err_val = '0, mst_lines = '0;
    logic        err_load = 1'b0;
    logic [31:0] fw_seg_sel;
    logic [7:0]  fw_rd_bytes;
    logic        sirq_en, sirq_quiet;
    logic [3:0]  sirq_start_clks;
    logic        ctl_irq, mst_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] C = 32'hC001_2000;
    localparam logic [31:0] M = 32'hC001_0000;

    always #5 clk = ~clk;

    lhc_regbank u_lhc_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .ctl_evt(ctl_evt),
        .err_load(err_load), .err_val(err_val), .mst_lines(mst_lines),
        .fw_seg_sel(fw_seg_sel), .fw_rd_bytes(fw_rd_bytes), .sirq_en(sirq_en),
        .sirq_quiet(sirq_quiet), .sirq_start_clks(sirq_start_clks),
        .ctl_irq(ctl_irq), .mst_irq(mst_irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read response against the queued expectation
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2: response %h with no expectation, expected none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            if (exp_q.size() != 0) begin
                tests++; fails++;
                $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
            end
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({31'd0, ctl_irq}, 32'd0, "R1 ctl_irq");
        check({31'd0, mst_irq}, 32'd0, "R1 mst_irq");
        check({24'd0, fw_rd_bytes}, 32'd4, "R1 fw_rd_bytes");
        check({28'd0, sirq_start_clks}, 32'd4, "R1 start clks");
        check({31'd0, sirq_en}, 32'd0, "R1 sirq_en");
        rd(C + 32'h24, 32'h0, "R1 seg");
        rd(C + 32'h28, 32'h0200_0000, "R1 rdsize");
        rd(C + 32'h30, 32'h0, "R1 sctl");
        rd(C + 32'h34, 32'h0, "R1 cmask");
        rd(C + 32'h38, 32'h0, "R1 cstat");
        rd(C + 32'h40, 32'h0, "R1 err");
        rd(M + 32'h50, 32'h0, "R1 mstat");
        rd(M + 32'h54, 32'h0, "R1 mmask");
        rd(M + 32'h58, 32'h0, "R1 mpol");
        rd(M + 32'h5C, 32'h0, "R1 mraw");

        // R2/R12 readback and decode
        wr(C + 32'h24, 32'hA5A5_5A5A);
        rd(C + 32'h24, 32'hA5A5_5A5A, "R2 seg readback");
        check(fw_seg_sel, 32'hA5A5_5A5A, "R12 fw_seg_sel");
        wr(C + 32'h28, 32'hFFFF_FFFF);
        rd(C + 32'h28, 32'h0700_0000, "R2 rdsize writable bits");
        check({24'd0, fw_rd_bytes}, 32'd128, "R12 size 128");
        wr(C + 32'h28, 32'h0400_0000);
        check({24'd0, fw_rd_bytes}, 32'd16, "R12 size 16");
        wr(C + 32'h28, 32'h0300_0000);
        check({24'd0, fw_rd_bytes}, 32'd4, "R12 reserved code");
        wr(C + 32'h28, 32'h0100_0000);
        check({24'd0, fw_rd_bytes}, 32'd2, "R12 size 2");
        wr(C + 32'h28, 32'h0);
        check({24'd0, fw_rd_bytes}, 32'd1, "R12 size 1");

        // R11 serial control
        wr(C + 32'h30, 32'hFFFF_FFFF);
        rd(C + 32'h30, 32'hC300_0000, "R2 sctl writable bits");
        check({30'd0, sirq_en, sirq_quiet}, 32'd3, "R11 en/quiet");
        check({28'd0, sirq_start_clks}, 32'd8, "R11 code 3");
        wr(C + 32'h30, 32'h8100_0000);
        check({30'd0, sirq_en, sirq_quiet}, 32'd2, "R11 en only");
        check({28'd0, sirq_start_clks}, 32'd6, "R11 code 1");
        wr(C + 32'h30, 32'h4200_0000);
        check({28'd0, sirq_start_clks}, 32'd8, "R11 code 2");
        wr(C + 32'h30, 32'h4000_0000);
        check({28'd0, sirq_start_clks}, 32'd4, "R11 code 0");

        // R3 unmapped space
        rd(C + 32'h2C, 32'hFFFF_FFFF, "R3 hole in ctl window");
        rd(C + 32'hFFC, 32'hFFFF_FFFF, "R3 ctl window end");
        rd(M + 32'h1000, 32'hFFFF_FFFF, "R3 hole in mst window");
        rd(32'h0000_0024, 32'hFFFF_FFFF, "R3 low address");
        rd(32'hC001_3024, 32'hFFFF_FFFF, "R3 past ctl window");
        wr(32'hC002_2024, 32'h1234_5678);
        wr(C + 32'h2C, 32'h0);
        rd(C + 32'h24, 32'hA5A5_5A5A, "R3 stray write no effect");

        // R4 invalid access shapes
        rd(C + 32'h24, 32'hFFFF_FFFF, "R4 half-word read", 4'h3);
        rd(C + 32'h25, 32'hFFFF_FFFF, "R4 misaligned read");
        wr(C + 32'h24, 32'h0, 4'h1);
        rd(C + 32'h24, 32'hA5A5_5A5A, "R4 byte write ignored");

        // R5 event strobes, implemented bits only
        @(negedge clk); ctl_evt = 32'hFFFF_FFFF;
        @(negedge clk); ctl_evt = 32'h0;
        rd(C + 32'h38, 32'hFFFF_84FF, "R5 status set");
        check({31'd0, ctl_irq}, 32'd0, "R8 masked off");
        wr(C + 32'h34, 32'h0000_0400);
        check({31'd0, ctl_irq}, 32'd1, "R8 mask enables irq");
        wr(C + 32'h38, 32'h0000_0400);
        check({31'd0, ctl_irq}, 32'd0, "R8 irq drops after clear");
        rd(C + 32'h38, 32'hFFFF_80FF, "R6 one bit cleared");
        wr(C + 32'h38, 32'hFFFF_FFFF);
        rd(C + 32'h38, 32'h0, "R6 all cleared");

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        ctl_evt = 32'h10; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = C + 32'h38;
        bus_wdata = 32'h10; bus_be = 4'hF;
        @(negedge clk);
        ctl_evt = 32'h0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(C + 32'h38, 32'h10, "R6 set beats clear");

        // R7 error address
        @(negedge clk); err_load = 1'b1; err_val = 32'hDEAD_BEE0;
        @(negedge clk); err_load = 1'b0; err_val = 32'h0;
        rd(C + 32'h40, 32'hDEAD_BEE0, "R7 loaded");
        wr(C + 32'h40, 32'h0);
        rd(C + 32'h40, 32'hDEAD_BEE0, "R7 bus write ignored");

        // R9/R10 master set (ctl_irq pulsed earlier, so clear first)
        wr(M + 32'h50, 32'hFFFF_FFFF);
        rd(M + 32'h50, 32'h0, "R6 master cleared");
        wr(C + 32'h34, 32'h10);
        check({31'd0, ctl_irq}, 32'd1, "R8 irq from bit 4");
        rd(M + 32'h5C, 32'h0000_0800, "R9 raw shows ctl irq");
        rd(M + 32'h50, 32'h0000_0800, "R10 master status from raw");
        check({31'd0, mst_irq}, 32'd0, "R10 master masked off");
        wr(M + 32'h54, 32'h0000_0800);
        check({31'd0, mst_irq}, 32'd1, "R10 master irq");
        wr(M + 32'h58, 32'h0000_0800);
        rd(M + 32'h5C, 32'h0, "R9 polarity inverts");
        wr(M + 32'h50, 32'h0000_0800);
        rd(M + 32'h50, 32'h0, "R6 master clear");
        check({31'd0, mst_irq}, 32'd0, "R10 master irq off");
        wr(M + 32'h5C, 32'hFFFF_FFFF);
        rd(M + 32'h5C, 32'h0, "R9 raw is read-only");
        @(negedge clk); mst_lines = 32'h0000_0805;
        rd(M + 32'h5C, 32'h0000_0005, "R9 lines merged with polarity");
        rd(M + 32'h50, 32'h0000_0005, "R10 level set");
        wr(M + 32'h50, 32'h1);
        rd(M + 32'h50, 32'h0000_0005, "R10 held while raw high");
        check({31'd0, mst_irq}, 32'd0, "R10 unmasked bits only");
        @(negedge clk); mst_lines = 32'h0;
        wr(M + 32'h50, 32'h5);
        rd(M + 32'h50, 32'h0, "R10 cleared once low");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule